// File: doc/BRIEF.md
# Single-Channel Masked-Address Copy Engine

This block moves a run of 32-bit words from one region of memory to another, one word at a time. A one-cycle start pulse loads a configuration. The configuration holds the start addresses, per-address wrap masks, per-address increment enables, a total word count, a chunk length and two mode bits. The engine then alternates a read request and a write request over valid/ready channels, so memory wait states stall it without losing data.

After every word each address advances by four, but only in the bit positions its mask selects. The bits outside the mask never change. A narrow mask therefore makes the address circle inside a small window, and a cleared increment enable keeps the address fixed. A chunk acknowledge pulses whenever the words moved so far fill a whole number of chunks. In handshake mode the engine only reads while a peripheral request line is high. When handshake mode and descriptor mode are both set, a next-descriptor line ends the run early. A stop line aborts the run with an error.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, busy, done, error, chunk_ack and done_irq are low, and rd_valid and wr_valid are low.
- R2: A start pulse while idle latches the configuration, clears done and error, and raises busy in the next cycle.
- R3: After each word an incrementing address becomes (addr AND NOT mask) OR ((addr + 4) AND mask). Bits outside the mask never change, so a mask of 0x0000000C cycles the address through four words of a 16-byte window.
- R4: When an increment enable is low, that address stays at its start value for the whole run, whatever its mask.
- R5: A chunk length of zero, or one larger than the total, acts as a chunk equal to the total.
- R6: chunk_ack is high for exactly one cycle after each word whose running count is a multiple of the effective chunk length, and is low at all other times.
- R7: In handshake mode no read is issued while hs_req is low, and the engine holds its place until the line rises.
- R8: stop while busy ends the run on the next edge with error high, busy low and done low. It takes priority over a word finishing in the same cycle, and no further write follows.
- R9: A run ends normally once the word count reaches the total. busy then falls, done rises and done_irq pulses for one cycle.
- R10: With handshake mode and descriptor mode both set, a high next_desc at the start, or at the completion of any word, ends the run with done high and no done_irq pulse. In any other mode next_desc has no effect.
- R11: Each word is read and then written. The written data equals the data returned by the read, and wr_addr and wr_data stay stable while wr_valid waits for wr_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, accepted while idle |
| cfg_src_addr | input | 32 | Source start byte address |
| cfg_dst_addr | input | 32 | Destination start byte address |
| cfg_src_mask | input | 32 | Source wrap mask |
| cfg_dst_mask | input | 32 | Destination wrap mask |
| cfg_src_inc | input | 1 | Source increment enable |
| cfg_dst_inc | input | 1 | Destination increment enable |
| cfg_total_words | input | 16 | Total words to move |
| cfg_chunk_words | input | 16 | Chunk length in words |
| cfg_hs_mode | input | 1 | Handshake mode: read only while hs_req is high |
| cfg_desc_mode | input | 1 | Descriptor mode: enables next_desc early end in handshake mode |
| hs_req | input | 1 | Peripheral request line |
| next_desc | input | 1 | Early-end request |
| stop | input | 1 | Abort request |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read byte address |
| rd_ready | input | 1 | Read accepted; rd_data valid in the same cycle |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accepted |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run ended without error |
| error | output | 1 | Last run was aborted |
| chunk_ack | output | 1 | One-cycle pulse at a chunk boundary |
| done_irq | output | 1 | One-cycle pulse at a normal end |

## Verification
The bench goes after a source window that wraps under a 0x0000000C mask and a destination held fixed by a cleared increment enable. A design that added four without masking would read past the window, and one that ignored the enable would spread its writes across memory. It also tries a chunk length of zero and one larger than the total. A design that did not substitute the total would drop or multiply its chunk acknowledges.

For the early-end line, the bench raises it at the start, on the same cycle as a word's write acceptance, and in a mode where it must be ignored. A wrong decode either cuts a plain run short or lets a done interrupt fire. The stop line is raised between words, and a design that finished one more word or never flagged the error leaves an extra write or a clear error. Random wait states on both channels, and random gaps in the request line, catch a design that moves data without the request or without the memory handshake.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eng_state_t;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] RST_MASK = {{(AW-2){1'b1}}, 2'b00}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask_cfg,
  input  logic          inc_en,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP_BYTES = AW'(dma_eng_pkg::WORD_BYTES);

  logic [AW-1:0] mask_q;
  logic [AW-1:0] addr_next;

  assign addr_next = (addr & ~mask_q) | ((addr + STEP_BYTES) & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      mask_q <= RST_MASK;
    end else if (load) begin
      addr   <= base;
      mask_q <= inc_en ? mask_cfg : '0;
    end else if (step) begin
      addr   <= addr_next;
    end
  end

  AST_OUTSIDE_MASK_FIXED: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (((addr ^ $past(addr)) & ~$past(mask_q)) == '0)); // R3
  AST_ADDR_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(addr)); // R4
endmodule

// File: rtl/dma_word_count.sv
module dma_word_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] total_cfg,
  input  logic [CW-1:0] chunk_cfg,
  input  logic          word_done,
  output logic          last_word,
  output logic          chunk_ack
);
  localparam int unsigned XW = CW + 1;

  logic [CW-1:0] total_q;
  logic [CW-1:0] chunk_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] chk_q;
  logic [CW-1:0] chk_inc;

  assign chk_inc   = chk_q + 1'b1;
  assign last_word = ({1'b0, cnt_q} + XW'(1)) >= {1'b0, total_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q   <= '0;
      chunk_q   <= '0;
      cnt_q     <= '0;
      chk_q     <= '0;
      chunk_ack <= 1'b0;
    end else if (load) begin
      total_q   <= total_cfg;
      chunk_q   <= ((chunk_cfg == '0) || (chunk_cfg > total_cfg)) ? total_cfg : chunk_cfg;
      cnt_q     <= '0;
      chk_q     <= '0;
      chunk_ack <= 1'b0;
    end else if (word_done) begin
      cnt_q <= cnt_q + 1'b1;
      if (chk_inc == chunk_q) begin
        chk_q     <= '0;
        chunk_ack <= 1'b1;
      end else begin
        chk_q     <= chk_inc;
        chunk_ack <= 1'b0;
      end
    end else begin
      chunk_ack <= 1'b0;
    end
  end

  AST_ACK_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (rst)
    chunk_ack |-> $past(word_done)); // R6
  AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (chunk_ack && !word_done) |=> !chunk_ack); // R6
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [AW-1:0] cfg_src_mask,
  input  logic [AW-1:0] cfg_dst_mask,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic [CW-1:0] cfg_total_words,
  input  logic [CW-1:0] cfg_chunk_words,
  input  logic          cfg_hs_mode,
  input  logic          cfg_desc_mode,
  input  logic          hs_req,
  input  logic          next_desc,
  input  logic          stop,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          chunk_ack,
  output logic          done_irq
);
  import dma_eng_pkg::*;

  eng_state_t state;
  logic hs_q, desc_q;
  logic load, word_done, last_word, skip_start, early_end;

  assign skip_start = cfg_hs_mode && cfg_desc_mode && next_desc;
  assign early_end  = hs_q && desc_q && next_desc;
  assign load       = (state == ST_IDLE) && go;
  assign rd_valid   = (state == ST_READ) && (!hs_q || hs_req);
  assign wr_valid   = (state == ST_WRITE);
  assign word_done  = (state == ST_WRITE) && wr_ready && !stop;

  dma_addr_gen #(.AW(AW)) u_src (
    .clk(clk), .rst(rst), .load(load), .base(cfg_src_addr), .mask_cfg(cfg_src_mask),
    .inc_en(cfg_src_inc), .step(word_done), .addr(rd_addr)
  );

  dma_addr_gen #(.AW(AW)) u_dst (
    .clk(clk), .rst(rst), .load(load), .base(cfg_dst_addr), .mask_cfg(cfg_dst_mask),
    .inc_en(cfg_dst_inc), .step(word_done), .addr(wr_addr)
  );

  dma_word_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .total_cfg(cfg_total_words),
    .chunk_cfg(cfg_chunk_words), .word_done(word_done),
    .last_word(last_word), .chunk_ack(chunk_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      done_irq <= 1'b0;
      hs_q     <= 1'b0;
      desc_q   <= 1'b0;
      wr_data  <= '0;
    end else begin
      done_irq <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            hs_q   <= cfg_hs_mode;
            desc_q <= cfg_desc_mode;
            error  <= 1'b0;
            if (skip_start) begin
              done <= 1'b1;
            end else begin
              done  <= 1'b0;
              busy  <= 1'b1;
              state <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (stop) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            error <= 1'b1;
          end else if (rd_valid && rd_ready) begin
            wr_data <= rd_data;
            state   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (stop) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            error <= 1'b1;
          end else if (wr_ready) begin
            if (early_end || last_word) begin
              state    <= ST_IDLE;
              busy     <= 1'b0;
              done     <= 1'b1;
              done_irq <= !early_end;
            end else begin
              state <= ST_READ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (busy && stop) |=> (error && !busy && !done)); // R8
  AST_HS_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && hs_q && !hs_req && !stop && !wr_valid) |=> (busy && !wr_valid)); // R7
  AST_END_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done != error)); // R9
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> (done && !busy)); // R9
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> busy); // R11
  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready && !stop) |=> ($stable(wr_data) && $stable(wr_addr))); // R11
endmodule

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0, cfg_src_mask = '0, cfg_dst_mask = '0;
  logic cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0, cfg_hs_mode = 1'b0, cfg_desc_mode = 1'b0;
  logic [15:0] cfg_total_words = '0, cfg_chunk_words = '0;
  logic hs_req = 1'b0, next_desc = 1'b0, stop = 1'b0;
  logic rd_valid, wr_valid, busy, done, error, chunk_ack, done_irq;
  logic [31:0] rd_addr, wr_addr, wr_data, rd_data;
  logic rd_ready = 1'b0, wr_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_engine dut (
    .clk(clk), .rst(rst), .go(go), .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_src_mask(cfg_src_mask), .cfg_dst_mask(cfg_dst_mask), .cfg_src_inc(cfg_src_inc),
    .cfg_dst_inc(cfg_dst_inc), .cfg_total_words(cfg_total_words), .cfg_chunk_words(cfg_chunk_words),
    .cfg_hs_mode(cfg_hs_mode), .cfg_desc_mode(cfg_desc_mode), .hs_req(hs_req),
    .next_desc(next_desc), .stop(stop), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .busy(busy), .done(done), .error(error),
    .chunk_ack(chunk_ack), .done_irq(done_irq)
  );

  logic [31:0] mem [0:MEMW-1];
  assign rd_data = mem[rd_addr[9:2]];

  int tests = 0, fails = 0;
  int sb_tests = 0, sb_fails = 0;
  int wr_cnt = 0, ack_cnt = 0, irq_cnt = 0;
  int wr_base = 0, nd_trig = 0, st_trig = 0;
  logic stall_en = 1'b0, hs_rand = 1'b0, nd_force = 1'b0;
  logic nd_hit = 1'b0, st_hit = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  logic [63:0] exp_q [$];

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops the expected write stream and counts pulses.
  always @(posedge clk) begin
    if (!rst) begin
      if (wr_valid && wr_ready && !stop) begin
        mem[wr_addr[9:2]] <= wr_data;
        wr_cnt <= wr_cnt + 1;
        sb_tests++;
        if (exp_q.size() == 0) begin
          sb_fails++;
          $display("FAIL R11 unexpected write actual=%0h expected=none", wr_addr);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          if (e != {wr_addr, wr_data}) begin
            sb_fails++;
            $display("FAIL R3/R4/R11 write actual=%0h expected=%0h", {wr_addr, wr_data}, e);
          end
        end
      end
      if (chunk_ack) ack_cnt <= ack_cnt + 1;
      if (done_irq) irq_cnt <= irq_cnt + 1;
    end
  end

  // Memory model: random wait states, request line and injections.
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_ready = stall_en ? lfsr[0] : 1'b1;
    wr_ready = stall_en ? lfsr[2] : 1'b1;
    if (hs_rand) hs_req = lfsr[3] | lfsr[6];
    if (nd_trig == 0) nd_hit = 1'b0;
    else if (busy && wr_valid && (wr_cnt - wr_base) == nd_trig - 1) begin
      nd_hit = 1'b1;
      wr_ready = 1'b1;
    end
    if (st_trig == 0) st_hit = 1'b0;
    else if (busy && (wr_cnt - wr_base) == st_trig) st_hit = 1'b1;
    if (st_hit) begin
      rd_ready = 1'b0;
      wr_ready = 1'b0;
    end
    next_desc = nd_force | nd_hit;
    stop = st_hit;
  end

  task automatic run_xfer(input logic [31:0] s, input logic [31:0] d, input logic [31:0] sm,
                          input logic [31:0] dm, input logic si, input logic di,
                          input int tot, input int ch, input logic hs, input logic de,
                          input int nd_at, input int st_at, input string tag);
    int ce, nw, exp_acks, exp_irq, a0, i0, cyc;
    logic [31:0] sa, da;
    logic early;
    ce = (ch == 0 || ch > tot) ? tot : ch;
    early = hs && de && nd_at > 0 && nd_at < tot;
    nw = tot;
    if (early) nw = nd_at;
    if (st_at > 0 && st_at < nw) nw = st_at;
    exp_irq = (early || st_at > 0) ? 0 : 1;
    exp_acks = 0;
    sa = s; da = d;
    for (int i = 0; i < nw; i++) begin
      exp_q.push_back({da, mem[sa[9:2]]});
      if (si) sa = (sa & ~sm) | ((sa + 32'd4) & sm);
      if (di) da = (da & ~dm) | ((da + 32'd4) & dm);
      if ((i + 1) % ce == 0) exp_acks++;
    end
    @(negedge clk);
    cfg_src_addr = s; cfg_dst_addr = d; cfg_src_mask = sm; cfg_dst_mask = dm;
    cfg_src_inc = si; cfg_dst_inc = di; cfg_total_words = 16'(tot); cfg_chunk_words = 16'(ch);
    cfg_hs_mode = hs; cfg_desc_mode = de;
    wr_base = wr_cnt; a0 = ack_cnt; i0 = irq_cnt;
    nd_trig = nd_at; st_trig = st_at;
    hs_req = 1'b0; hs_rand = 1'b0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(busy && !done && !error, {"R2 ", tag}, {busy, done, error}, 3'b100);
    if (hs) begin
      logic saw;
      saw = 1'b0;
      for (int k = 0; k < 12; k++) begin
        if (rd_valid) saw = 1'b1;
        @(negedge clk);
      end
      check(!saw && busy && (wr_cnt == wr_base), {"R7 ", tag}, saw, 0);
      hs_rand = 1'b1;
    end
    cyc = 0;
    while (busy && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    check(!busy, {"R9 ", tag}, busy, 0);
    check(wr_cnt - wr_base == nw, {"R11 ", tag}, wr_cnt - wr_base, nw);
    check(exp_q.size() == 0, {"R11 ", tag}, exp_q.size(), 0);
    check(ack_cnt - a0 == exp_acks, {"R6/R5 ", tag}, ack_cnt - a0, exp_acks);
    check(irq_cnt - i0 == exp_irq, {"R9/R10 ", tag}, irq_cnt - i0, exp_irq);
    if (st_at > 0) check(error && !done, {"R8 ", tag}, {done, error}, 2'b01);
    else check(done && !error, {"R9 ", tag}, {done, error}, 2'b10);
    nd_trig = 0; st_trig = 0; hs_rand = 1'b0; exp_q.delete();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests + sb_tests + 1, fails + sb_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMW; i++) mem[i] = 32'hC0DE_0000 | 32'(i * 7);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !error && !chunk_ack && !done_irq && !rd_valid && !wr_valid,
          "R1 reset", {busy, done, error, chunk_ack, done_irq, rd_valid, wr_valid}, 0);

    // R3 linear copy with chunk 3; R6 acks at words 3 and 6
    run_xfer(32'h0, 32'h200, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1, 1, 8, 3, 0, 0, 0, 0, "linear");
    stall_en = 1'b1;
    // R3 source wraps in a 16-byte window; R5 chunk 0
    run_xfer(32'h100, 32'h280, 32'h0000_000C, 32'hFFFF_FFFC, 1, 1, 6, 0, 0, 0, 0, 0, "wrap");
    // R4 destination fixed despite a full mask
    run_xfer(32'h040, 32'h300, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1, 0, 5, 2, 0, 0, 0, 0, "fixed dst");
    // R4 source fixed; R5 chunk larger than total
    run_xfer(32'h0A0, 32'h340, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 0, 1, 4, 9, 0, 0, 0, 0, "fixed src");
    // R7 handshake mode with gaps in the request line
    run_xfer(32'h080, 32'h380, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1, 1, 7, 2, 1, 0, 0, 0, "handshake");
    // R10 early end after word 3
    run_xfer(32'h020, 32'h3A0, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1, 1, 8, 2, 1, 1, 3, 0, "early end");
    // R10 next_desc ignored without descriptor mode
    run_xfer(32'h020, 32'h3C0, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1, 1, 6, 0, 1, 0, 2, 0, "nd ignored");
    // R8 stop after 3 words
    run_xfer(32'h060, 32'h3E0, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1, 1, 8, 4, 0, 0, 0, 3, "stop");
    // R2 restart after error clears error
    run_xfer(32'h000, 32'h200, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1, 1, 3, 1, 0, 0, 0, 0, "restart");

    // R10 early end at start: no write, done high, no irq
    begin
      int w0, i0;
      @(negedge clk);
      w0 = wr_cnt; i0 = irq_cnt;
      cfg_hs_mode = 1'b1; cfg_desc_mode = 1'b1; cfg_total_words = 16'd4;
      nd_force = 1'b1;
      @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      check(done && !busy && !error, "R10 start skip flags", {busy, done, error}, 3'b010);
      repeat (4) @(negedge clk);
      check(wr_cnt == w0 && irq_cnt == i0 && !rd_valid, "R10 start skip no data",
            wr_cnt - w0, 0);
      nd_force = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", tests + sb_tests, fails + sb_fails);
    $finish;
  end
endmodule